// File: doc/BRIEF.md
# Inclusive Snoop-Filter Directory

This block is a tag-only directory that sits beside the private caches of several cores. For every line it tracks, it keeps a tag and one bit per core. A set bit means that core may hold a copy. The bit is conservative: the core might already have dropped the line. The directory stores no line data.

Cores send three kinds of notice: a fill when they bring a line in, an eviction when they drop one, and a request for exclusive ownership before they write. An exclusive request sends invalidations only to the cores whose bits are set, never to the requester and never to all cores. The grant is issued once every targeted core has acknowledged. The directory is inclusive. When it has to reuse a way whose entry still has holders, it first invalidates that line in every core recorded as a holder, and only then installs the new line.

The table is set-associative with least-recently-used replacement. An entry whose presence bits are all zero counts as free. The directory handles one request at a time. While invalidations are in flight it lowers its ready signal, so it stalls all new requests, including any to the line being invalidated.

Top module: `snoop_filter`

## Requirements
- R1: Each entry holds a line tag and one presence bit per core. A fill notice (reqOp 2'b00) from core c sets bit c, either in the existing entry or in a newly allocated one. The address is a line address: the low log2(SETS) bits select the set and the remaining bits form the tag.
- R2: An exclusive request (reqOp 2'b10) that hits asserts invReq only for the cores whose presence bits are set, excluding the requester. With no such core it raises no invReq and grants on the next cycle.
- R3: Each invReq bit stays high until the matching invAck bit is seen at a clock edge. invAddr holds the targeted line address throughout. grantValid is never high while any invReq bit is high.
- R4: After an exclusive grant, the entry's presence vector holds only the requester's bit.
- R5: An eviction notice (reqOp 2'b01) clears the sender's bit for that line. An eviction notice for a line that is not tracked has no effect.
- R6: On a miss, the lowest-numbered way whose presence vector is all zero is allocated. If there is none, the least-recently-used way is allocated. Fills and exclusive requests update recency. Eviction notices do not.
- R7: If the chosen way still has holders, invReq is raised for exactly those cores, with invAddr set to the old line ({old tag, set}). After all acknowledgements the new line is installed with only the requester's bit set. An exclusive miss then grants.
- R8: reqReady is low from the cycle after a request that needs invalidations is accepted until the transaction completes. No request is accepted in that period.
- R9: After reset the table is empty, reqReady is high, and invReq and grantValid are low.
- R10: grantValid is a one-cycle pulse carrying the requester's core in grantCore and the line address in grantAddr. It appears one cycle after acceptance when no invalidation is needed, or two edges after the last acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 00 fill, 01 eviction, 10 exclusive, 11 ignored |
| reqCore | input | log2(NUM_CORES) | Requesting core |
| reqAddr | input | ADDR_W | Line address |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| invReq | output | NUM_CORES | Per-core invalidation request, held until acknowledged |
| invAddr | output | ADDR_W | Line being invalidated |
| invAck | input | NUM_CORES | Per-core invalidation acknowledgement |
| grantValid | output | 1 | Exclusive ownership granted |
| grantCore | output | log2(NUM_CORES) | Core receiving the grant |
| grantAddr | output | ADDR_W | Line granted |

## Verification
Wrong presence bits or a wrong tag stay hidden until a later exclusive request or a back-invalidation touches that entry. At that point they show as a wrong invReq vector or invAddr, one cycle after the request is accepted. The bench therefore mixes fills, evictions and exclusive requests over a small pool of addresses, so that every entry is soon probed by an exclusive request or a replacement. A wrong recency order shows only when a set is full: the back-invalidation then targets the wrong old line. Errors in the handshake show in the same transaction: a grant arriving too early or too late, or reqReady staying high during a wait.

// File: rtl/sf_pkg.sv
package sf_pkg;

  typedef enum logic [1:0] {
    OP_FILL  = 2'b00,
    OP_EVICT = 2'b01,
    OP_EXCL  = 2'b10,
    OP_NONE  = 2'b11
  } reqOp_e;

  // Strobes from control to the directory storage
  typedef struct packed {
    logic install;   // write tag, presence := mask
    logic orBits;    // presence |= mask
    logic clrBits;   // presence &= ~mask
    logic touch;     // make way most recently used
  } sfStrobe_t;

endpackage

// File: rtl/sf_datapath.sv
module sf_datapath #(
  parameter int NUM_CORES = 4,
  parameter int WAYS      = 4,
  parameter int SETS      = 4,
  parameter int ADDR_W    = 12,
  localparam int SET_W    = $clog2(SETS),
  localparam int TAG_W    = ADDR_W - SET_W,
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     lookAddr,
  input  sf_pkg::sfStrobe_t     strb,
  input  logic [SET_W-1:0]      wrSet,
  input  logic [WAY_W-1:0]      wrWay,
  input  logic [TAG_W-1:0]      wrTag,
  input  logic [NUM_CORES-1:0]  wrMask,
  output logic                  hit,
  output logic [WAY_W-1:0]      hitWay,
  output logic [NUM_CORES-1:0]  hitPres,
  output logic [WAY_W-1:0]      vicWay,
  output logic [NUM_CORES-1:0]  vicPres,
  output logic [TAG_W-1:0]      vicTag
);

  logic [TAG_W-1:0]     tagArr  [SETS][WAYS];
  logic [NUM_CORES-1:0] presArr [SETS][WAYS];
  logic [WAY_W-1:0]     ageArr  [SETS][WAYS];

  logic [SET_W-1:0] lkSet;
  logic [TAG_W-1:0] lkTag;
  assign lkSet = lookAddr[SET_W-1:0];
  assign lkTag = lookAddr[ADDR_W-1:SET_W];

  logic [WAYS-1:0] matchVec, freeVec, oldVec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign matchVec[w] = (|presArr[lkSet][w]) && (tagArr[lkSet][w] == lkTag);
    assign freeVec[w]  = ~|presArr[lkSet][w];
    assign oldVec[w]   = (ageArr[lkSet][w] == WAY_W'(WAYS - 1));
  end

  logic              freeAny;
  logic [WAY_W-1:0]  freeWay, lruWay;

  always_comb begin
    hitWay  = '0;
    freeWay = '0;
    lruWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) hitWay  = WAY_W'(w);
      if (freeVec[w])  freeWay = WAY_W'(w);
      if (oldVec[w])   lruWay  = WAY_W'(w);
    end
  end

  assign hit     = |matchVec;
  assign freeAny = |freeVec;
  assign hitPres = presArr[lkSet][hitWay];
  assign vicWay  = freeAny ? freeWay : lruWay;
  assign vicPres = presArr[lkSet][vicWay];
  assign vicTag  = tagArr[lkSet][vicWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tagArr[s][w]  <= '0;
          presArr[s][w] <= '0;
          ageArr[s][w]  <= WAY_W'(w);
        end
      end
    end else begin
      if (strb.install) begin
        tagArr[wrSet][wrWay]  <= wrTag;
        presArr[wrSet][wrWay] <= wrMask;
      end else if (strb.orBits) begin
        presArr[wrSet][wrWay] <= presArr[wrSet][wrWay] | wrMask;
      end else if (strb.clrBits) begin
        presArr[wrSet][wrWay] <= presArr[wrSet][wrWay] & ~wrMask;
      end
      if (strb.touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (ageArr[wrSet][w] < ageArr[wrSet][wrWay])
            ageArr[wrSet][w] <= ageArr[wrSet][w] + 1'b1;
        end
        ageArr[wrSet][wrWay] <= '0;
      end
    end
  end

endmodule

// File: rtl/sf_ctrl.sv
module sf_ctrl #(
  parameter int NUM_CORES = 4,
  parameter int WAYS      = 4,
  parameter int SETS      = 4,
  parameter int ADDR_W    = 12,
  localparam int SET_W    = $clog2(SETS),
  localparam int TAG_W    = ADDR_W - SET_W,
  localparam int WAY_W    = $clog2(WAYS),
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  sf_pkg::reqOp_e        reqOp,
  input  logic [CORE_W-1:0]     reqCore,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  reqReady,
  output logic [NUM_CORES-1:0]  invReq,
  output logic [ADDR_W-1:0]     invAddr,
  input  logic [NUM_CORES-1:0]  invAck,
  output logic                  grantValid,
  output logic [CORE_W-1:0]     grantCore,
  output logic [ADDR_W-1:0]     grantAddr,
  input  logic                  hit,
  input  logic [WAY_W-1:0]      hitWay,
  input  logic [NUM_CORES-1:0]  hitPres,
  input  logic [WAY_W-1:0]      vicWay,
  input  logic [NUM_CORES-1:0]  vicPres,
  input  logic [TAG_W-1:0]      vicTag,
  output sf_pkg::sfStrobe_t     strb,
  output logic [SET_W-1:0]      wrSet,
  output logic [WAY_W-1:0]      wrWay,
  output logic [TAG_W-1:0]      wrTag,
  output logic [NUM_CORES-1:0]  wrMask
);
  import sf_pkg::*;

  typedef enum logic {S_IDLE, S_WAIT} state_e;

  state_e               state, nextState;
  logic [NUM_CORES-1:0] pend, newPend;
  logic [ADDR_W-1:0]    lineQ, newLine, addrQ;
  logic [WAY_W-1:0]     wayQ, newWay;
  logic [CORE_W-1:0]    coreQ;
  logic                 exclQ, startInv, grantNow;
  logic [CORE_W-1:0]    grantCoreN;
  logic [ADDR_W-1:0]    grantAddrN;

  logic [NUM_CORES-1:0] reqBit, coreBitQ;
  logic [SET_W-1:0]     reqSet;
  logic [TAG_W-1:0]     reqTag;

  assign reqBit   = NUM_CORES'(1) << reqCore;
  assign coreBitQ = NUM_CORES'(1) << coreQ;
  assign reqSet   = reqAddr[SET_W-1:0];
  assign reqTag   = reqAddr[ADDR_W-1:SET_W];

  assign reqReady = (state == S_IDLE);
  assign invReq   = pend;
  assign invAddr  = lineQ;

  always_comb begin
    strb       = '0;
    wrSet      = reqSet;
    wrWay      = hitWay;
    wrTag      = reqTag;
    wrMask     = '0;
    nextState  = state;
    startInv   = 1'b0;
    newPend    = '0;
    newLine    = reqAddr;
    newWay     = hitWay;
    grantNow   = 1'b0;
    grantCoreN = reqCore;
    grantAddrN = reqAddr;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          case (reqOp)
            OP_FILL, OP_EXCL: begin
              if (hit) begin
                if (reqOp == OP_FILL) begin
                  strb.orBits = 1'b1; strb.touch = 1'b1; wrMask = reqBit;
                end else if ((hitPres & ~reqBit) == '0) begin
                  strb.install = 1'b1; strb.touch = 1'b1; wrMask = reqBit;
                  grantNow = 1'b1;
                end else begin
                  startInv = 1'b1; newPend = hitPres & ~reqBit;
                end
              end else if (vicPres == '0) begin
                strb.install = 1'b1; strb.touch = 1'b1;
                wrWay = vicWay; wrMask = reqBit;
                grantNow = (reqOp == OP_EXCL);
              end else begin
                startInv = 1'b1; newPend = vicPres;
                newLine = {vicTag, reqSet}; newWay = vicWay;
              end
            end
            OP_EVICT: begin
              if (hit) begin
                strb.clrBits = 1'b1; wrMask = reqBit;
              end
            end
            default: ;
          endcase
          if (startInv) nextState = S_WAIT;
        end
      end
      S_WAIT: begin
        wrSet = addrQ[SET_W-1:0];
        wrWay = wayQ;
        wrTag = addrQ[ADDR_W-1:SET_W];
        if (pend != '0) begin
          strb.clrBits = 1'b1; wrMask = pend & invAck;
        end else begin
          strb.install = 1'b1; strb.touch = 1'b1; wrMask = coreBitQ;
          grantNow = exclQ; grantCoreN = coreQ; grantAddrN = addrQ;
          nextState = S_IDLE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pend       <= '0;
      lineQ      <= '0;
      addrQ      <= '0;
      wayQ       <= '0;
      coreQ      <= '0;
      exclQ      <= 1'b0;
      grantValid <= 1'b0;
      grantCore  <= '0;
      grantAddr  <= '0;
    end else begin
      state      <= nextState;
      grantValid <= grantNow;
      if (grantNow) begin
        grantCore <= grantCoreN;
        grantAddr <= grantAddrN;
      end
      if (startInv) begin
        pend  <= newPend;
        lineQ <= newLine;
        wayQ  <= newWay;
        addrQ <= reqAddr;
        coreQ <= reqCore;
        exclQ <= (reqOp == OP_EXCL);
      end else if (state == S_WAIT) begin
        pend <= pend & ~invAck;
      end
    end
  end

endmodule

// File: rtl/snoop_filter.sv
module snoop_filter #(
  parameter int NUM_CORES = 4,
  parameter int WAYS      = 4,
  parameter int SETS      = 4,
  parameter int ADDR_W    = 12,
  localparam int SET_W    = $clog2(SETS),
  localparam int TAG_W    = ADDR_W - SET_W,
  localparam int WAY_W    = $clog2(WAYS),
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 reqReady,
  output logic [NUM_CORES-1:0] invReq,
  output logic [ADDR_W-1:0]    invAddr,
  input  logic [NUM_CORES-1:0] invAck,
  output logic                 grantValid,
  output logic [CORE_W-1:0]    grantCore,
  output logic [ADDR_W-1:0]    grantAddr
);

  sf_pkg::sfStrobe_t    strb;
  logic [SET_W-1:0]     wrSet;
  logic [WAY_W-1:0]     wrWay, hitWay, vicWay;
  logic [TAG_W-1:0]     wrTag, vicTag;
  logic [NUM_CORES-1:0] wrMask, hitPres, vicPres;
  logic                 hit;

  sf_ctrl #(.NUM_CORES(NUM_CORES), .WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(sf_pkg::reqOp_e'(reqOp)),
    .reqCore(reqCore), .reqAddr(reqAddr), .reqReady(reqReady), .invReq(invReq),
    .invAddr(invAddr), .invAck(invAck), .grantValid(grantValid), .grantCore(grantCore),
    .grantAddr(grantAddr), .hit(hit), .hitWay(hitWay), .hitPres(hitPres),
    .vicWay(vicWay), .vicPres(vicPres), .vicTag(vicTag), .strb(strb),
    .wrSet(wrSet), .wrWay(wrWay), .wrTag(wrTag), .wrMask(wrMask)
  );

  sf_datapath #(.NUM_CORES(NUM_CORES), .WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .lookAddr(reqAddr), .strb(strb), .wrSet(wrSet),
    .wrWay(wrWay), .wrTag(wrTag), .wrMask(wrMask), .hit(hit), .hitWay(hitWay),
    .hitPres(hitPres), .vicWay(vicWay), .vicPres(vicPres), .vicTag(vicTag)
  );

endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 12,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqReady,
  input logic [NUM_CORES-1:0] invReq,
  input logic [ADDR_W-1:0]    invAddr,
  input logic [NUM_CORES-1:0] invAck,
  input logic                 grantValid,
  input logic [CORE_W-1:0]    grantCore
);

  // R3
  grant_after_acks_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (invReq == '0));

  // R3
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(invReq & ~invAck)) |=> ((($past(invReq) & ~$past(invAck)) & ~invReq) == '0));

  // R3
  inv_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invReq != '0) |=> ((invReq == '0) || $stable(invAddr)));

  // R2
  no_new_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invReq != '0) |=> ((invReq & ~$past(invReq)) == '0));

  // R8
  stall_while_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invReq != '0) |-> !reqReady);

  // R10
  grant_core_known_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> !$isunknown(grantCore));

endmodule

bind snoop_filter sf_checker #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .invReq(invReq), .invAddr(invAddr),
  .invAck(invAck), .grantValid(grantValid), .grantCore(grantCore)
);

// File: tb/tb_snoop_filter.sv
`timescale 1ns/1ps
module tb_snoop_filter;
  localparam int NC = 4, NW = 4, NS = 4, AW = 12;

  logic          clk = 1'b0, rstN = 1'b0, reqValid = 1'b0;
  logic [1:0]    reqOp = 2'b00;
  logic [1:0]    reqCore = '0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqReady, grantValid;
  logic [NC-1:0] invReq, invAck = '0;
  logic [AW-1:0] invAddr, grantAddr;
  logic [1:0]    grantCore;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  snoop_filter #(.NUM_CORES(NC), .WAYS(NW), .SETS(NS), .ADDR_W(AW)) dut (.*);

  // Reference directory state
  int            mTag  [NS][NW];
  logic [NC-1:0] mPres [NS][NW];
  int            mAge  [NS][NW];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int findHit(int s, int t);
    for (int w = 0; w < NW; w++) if (mPres[s][w] != 0 && mTag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int pickVictim(int s);
    for (int w = 0; w < NW; w++) if (mPres[s][w] == 0) return w;
    for (int w = 0; w < NW; w++) if (mAge[s][w] == NW - 1) return w;
    return 0;
  endfunction

  task automatic touch(int s, int way);
    for (int w = 0; w < NW; w++) if (mAge[s][w] < mAge[s][way]) mAge[s][w]++;
    mAge[s][way] = 0;
  endtask

  task automatic doReq(int op, int core, int addr);
    int s = addr % NS, t = addr / NS, way;
    logic [NC-1:0] bitC = NC'(1) << core;
    logic [NC-1:0] expInv = '0;
    int expLine = addr;
    bit expGrant = (op == 2);
    string tag = "R1 R2 R4 R5";
    way = findHit(s, t);
    if (op == 1) begin
      if (way >= 0) mPres[s][way] &= ~bitC;
    end else if (way >= 0) begin
      if (op == 0) mPres[s][way] |= bitC;
      else begin expInv = mPres[s][way] & ~bitC; mPres[s][way] = bitC; end
      touch(s, way);
    end else begin
      way = pickVictim(s);
      if (mPres[s][way] != 0) begin
        expInv = mPres[s][way]; expLine = mTag[s][way] * NS + s; tag = "R6 R7";
      end
      mTag[s][way] = t; mPres[s][way] = bitC;
      touch(s, way);
    end

    @(negedge clk);
    chk(reqReady == 1'b1, "R8", "ready before request", reqReady, 1);
    reqValid = 1'b1; reqOp = 2'(op); reqCore = 2'(core); reqAddr = AW'(addr);
    @(negedge clk);
    reqValid = 1'b0;
    chk(invReq == expInv, tag, "invalidation targets", invReq, expInv);
    if (expInv != 0) begin
      chk(invAddr == AW'(expLine), "R3 R7", "invalidation line", invAddr, expLine);
      while (invReq != 0) begin
        chk(reqReady == 1'b0, "R8", "stall during invalidation", reqReady, 0);
        chk(grantValid == 1'b0, "R3", "no grant before acks", grantValid, 0);
        invAck = invReq & NC'($urandom());
        @(negedge clk);
      end
      invAck = '0;
      @(negedge clk);
    end
    chk(grantValid == expGrant, "R10", "grant pulse", grantValid, expGrant);
    if (expGrant) begin
      chk(grantCore == 2'(core), "R10", "grant core", grantCore, core);
      chk(grantAddr == AW'(addr), "R10", "grant line", grantAddr, addr);
      @(negedge clk);
      chk(grantValid == 1'b0, "R10", "grant one cycle", grantValid, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5F17;
    void'($urandom(seed));
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin mTag[s][w] = 0; mPres[s][w] = '0; mAge[s][w] = w; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(reqReady == 1'b1, "R9", "ready after reset", reqReady, 1);
    chk(invReq == '0, "R9", "no inv after reset", invReq, 0);
    chk(grantValid == 1'b0, "R9", "no grant after reset", grantValid, 0);

    // R2 exclusive on empty table: immediate grant
    doReq(2, 0, 8'h10);
    // R1 fills add holders; R2 R4 exclusive targets others only
    doReq(0, 1, 8'h10);
    doReq(0, 2, 8'h10);
    doReq(2, 3, 8'h10);
    doReq(2, 3, 8'h10);
    // R5 eviction clears, untracked eviction ignored
    doReq(1, 3, 8'h10);
    doReq(0, 2, 8'h21);
    doReq(1, 1, 8'h21);
    doReq(1, 0, 8'h35);
    doReq(2, 0, 8'h21);
    // R6 R7 fill five tags into set 2 to force back-invalidation
    for (int i = 0; i < 5; i++) doReq(0, i % NC, (i + 1) * NS + 2);
    doReq(2, 1, 7 * NS + 2);

    // Random mix over a small line pool
    for (int n = 0; n < 600; n++)
      doReq($urandom() % 3, $urandom() % NC, ($urandom() % 6) * NS + ($urandom() % 2));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule